// File: doc/BRIEF.md
# Shared PHY Power Sequencer

This block powers a multi-lane PHY up and down for several lane users that share it. Each user sends one enable or disable request at a time. The block keeps a count of active users. The first enable, which takes the count from zero to one, runs a bring-up sequence:

1. Release the PHY reset.
2. Clear the idle bits of every lane.
3. Wait for the PLL to lock.
4. Reprogram the PLL clock settings.
5. Wait until the reference clock output is ungated and the PLL has locked again.

Later enables only raise the count. A disable idles the requesting lane and lowers the count. When the count reaches zero, the PHY goes back into reset.

The PHY is reached through a small configuration port. It has a 6-bit address, 4 bits of write data, a write strobe with fixed high and low times, and 4 bits of read data that the block samples after a fixed settle time. All delays come from a cycles-per-microsecond parameter, so a test can run the block on a short time scale. While a request is being served, `busy` is high and no new request is taken. A requester holds `req_valid` until the block accepts it. Every request ends with a one-cycle `done` pulse. That pulse may come with a timeout flag or a misuse flag.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, `phy_rst` is 1, `lane_idle` is all ones, and `busy`, `done`, `err_timeout`, `err_pair` and `cfg_wstrobe` are 0.
- R2: An enable accepted while the user count is 0 sets the count to 1. The block then drops `phy_rst`, and only after that clears every `lane_idle` bit. It then reads address 0x10 until bit 1 (PLL locked) is 1.
- R3: After the first lock, the block writes 0x8 (bit 3 set) to address 0x10 to fix the PLL rate, then writes 0x8 to address 0x12 to turn on the 100 MHz reference output. These are the only two writes in a bring-up, and they come in that order.
- R4: Next, the block reads address 0x12 until bit 2 (output gated) is 0. Then it reads address 0x10 until bit 1 is 1 again. It then pulses `done` with both error flags at 0, leaving `phy_rst` at 0 and all `lane_idle` bits at 0.
- R5: Each of the three polls makes at most MAX_TRIES reads, with GAP_US microseconds of wait between them. If the last read still fails, the block pulses `done` together with `err_timeout`. The count stays at 1 and `phy_rst` stays at 0, so a later enable finishes at once.
- R6: For a write, the block sets address and data one cycle before `cfg_wstrobe` rises. The strobe stays high for HOLD_US·CYC_PER_US cycles, then stays low for the same time before the write completes. For a read, the block sets the address and samples `cfg_rdata` after that same number of cycles.
- R7: An enable accepted while the count is above 0 only raises the count. `done` pulses one cycle after acceptance, no error flag is raised, and no config write occurs.
- R8: A disable accepted while the count is above 0 lowers the count and sets only the `lane_idle` bit of `req_lane`. If the count becomes 0, `phy_rst` rises with the same `done`.
- R9: A disable accepted while the count is 0 pulses `done` with `err_pair`. It changes no count, no `lane_idle` bit and no `phy_rst`.
- R10: `busy` is high from the cycle after a sequence is accepted until its `done`. Requests raised while `busy` is high are not accepted and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until accepted while not busy |
| req_enable | input | 1 | 1 = enable, 0 = disable |
| req_lane | input | LANE_W | Lane of the requester |
| busy | output | 1 | Bring-up sequence in progress |
| done | output | 1 | One-cycle completion pulse for every accepted request |
| err_timeout | output | 1 | With `done`: a poll ran out of tries |
| err_pair | output | 1 | With `done`: disable with no active user |
| phy_rst | output | 1 | PHY reset, 1 = held in reset |
| lane_idle | output | LANES | Per-lane idle control, 1 = idle |
| cfg_addr | output | 6 | Config port address |
| cfg_wdata | output | 4 | Config port write data |
| cfg_wstrobe | output | 1 | Config port write strobe |
| cfg_rdata | input | 4 | Config port read data |

## Verification
The assertions check the following on every cycle:
- Address and data are stable when the strobe rises, and the strobe is never high longer than its hold time.
- The reset is released only with a count of one, and lanes leave idle only once the reset is off.
- The count changes only when a request is accepted in the idle state, and a misuse disable leaves the count at zero.
- The poll counter stays within its bound, and every error flag comes with `done`.

Only the bench scenarios can show the rest, by driving a modelled PLL and reference gate with chosen delays:
- the order and values of the two writes;
- the success or timeout of each of the three polls;
- the one-cycle answer to repeated enables;
- per-lane idling;
- that a misuse disable and a request held against `busy` leave `lane_idle` and `phy_rst` untouched.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam int CFG_AW = 6;
  localparam int CFG_DW = 4;

  localparam logic [CFG_AW-1:0] ADDR_PLL = 6'h10;
  localparam logic [CFG_AW-1:0] ADDR_REF = 6'h12;

  typedef enum logic [2:0] {
    S_IDLE, S_RELEASE, S_UNIDLE, S_ISSUE, S_WAIT, S_GAP
  } seq_state_t;

  // order of the bring-up steps is behaviour: enum order = execution order
  typedef enum logic [2:0] {
    ST_LOCK, ST_RATE, ST_REFOUT, ST_UNGATE, ST_RELOCK
  } step_t;

  function automatic int unsigned us_to_cycles(int unsigned us, int unsigned cyc_per_us);
    int unsigned r;
    r = us * cyc_per_us;
    return (r == 0) ? 1 : r;
  endfunction

  function automatic logic step_is_write(step_t s);
    return (s == ST_RATE) || (s == ST_REFOUT);
  endfunction

  function automatic logic [CFG_AW-1:0] step_addr(step_t s);
    return ((s == ST_REFOUT) || (s == ST_UNGATE)) ? ADDR_REF : ADDR_PLL;
  endfunction

  function automatic logic [CFG_DW-1:0] step_wdata(step_t s);
    return step_is_write(s) ? 4'b1000 : 4'b0000;
  endfunction

  // poll success: ungate step wants bit 2 clear, lock steps want bit 1 set
  function automatic logic poll_met(step_t s, logic [CFG_DW-1:0] rd);
    return (s == ST_UNGATE) ? ~rd[2] : rd[1];
  endfunction

endpackage

// File: rtl/phy_delay.sv
module phy_delay #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);

  logic          run;
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= CW'(CYCLES - 1);
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/phy_user_count.sv
module phy_user_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             is_zero
);
  assign is_zero = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                         count <= '0;
    else if (inc && (count != '1))      count <= count + 1'b1;
    else if (dec && !is_zero)           count <= count - 1'b1;
  end

  assert_pair_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && is_zero) |=> is_zero);
endmodule

// File: rtl/phy_cfg_port.sv
module phy_cfg_port
  import phy_seq_pkg::*;
#(
  parameter int unsigned HOLD = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic              op_done,
  output logic [CFG_DW-1:0] op_rdata,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [CFG_DW-1:0] cfg_wdata,
  output logic              cfg_wstrobe,
  input  logic [CFG_DW-1:0] cfg_rdata
);
  localparam int CW = $clog2(HOLD + 1);

  typedef enum logic [2:0] {C_IDLE, C_WSET, C_WHI, C_WLO, C_RD} cfg_state_t;

  cfg_state_t    cst;
  logic [CW-1:0] cnt;
  logic          hold_end;

  assign hold_end = (cnt == CW'(HOLD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cst         <= C_IDLE;
      cnt         <= '0;
      cfg_addr    <= '0;
      cfg_wdata   <= '0;
      cfg_wstrobe <= 1'b0;
      op_done     <= 1'b0;
      op_rdata    <= '0;
    end else begin
      op_done <= 1'b0;
      case (cst)
        C_IDLE: if (start) begin
          cfg_addr  <= addr;
          cfg_wdata <= is_write ? wdata : '0;
          cnt       <= '0;
          cst       <= is_write ? C_WSET : C_RD;
        end
        C_WSET: begin
          cfg_wstrobe <= 1'b1;
          cnt         <= '0;
          cst         <= C_WHI;
        end
        C_WHI: begin
          cnt <= cnt + 1'b1;
          if (hold_end) begin
            cfg_wstrobe <= 1'b0;
            cnt         <= '0;
            cst         <= C_WLO;
          end
        end
        C_WLO: begin
          cnt <= cnt + 1'b1;
          if (hold_end) begin
            op_done <= 1'b1;
            cst     <= C_IDLE;
          end
        end
        C_RD: begin
          cnt <= cnt + 1'b1;
          if (hold_end) begin
            op_rdata <= cfg_rdata;
            op_done  <= 1'b1;
            cst      <= C_IDLE;
          end
        end
        default: cst <= C_IDLE;
      endcase
    end
  end

  // checker state: strobe high-time counter and history flag
  logic          past_ok;
  logic [CW:0]   hi_len;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      hi_len  <= '0;
    end else begin
      past_ok <= 1'b1;
      hi_len  <= cfg_wstrobe ? hi_len + 1'b1 : '0;
    end
  end

  assert_strobe_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(cfg_wstrobe)) |-> ($stable(cfg_addr) && $stable(cfg_wdata)));
  assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_len <= (CW+1)'(HOLD));
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_seq_pkg::*;
#(
  parameter int          LANES      = 4,
  parameter int          CNT_W      = 4,
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned HOLD_US    = 10,
  parameter int unsigned GAP_US     = 1000,
  parameter int unsigned MAX_TRIES  = 100,
  localparam int         LANE_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_enable,
  input  logic [LANE_W-1:0] req_lane,
  output logic              busy,
  output logic              done,
  output logic              err_timeout,
  output logic              err_pair,
  output logic              phy_rst,
  output logic [LANES-1:0]  lane_idle,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [CFG_DW-1:0] cfg_wdata,
  output logic              cfg_wstrobe,
  input  logic [CFG_DW-1:0] cfg_rdata
);
  localparam int unsigned HOLD_CYC = us_to_cycles(HOLD_US, CYC_PER_US);
  localparam int unsigned GAP_CYC  = us_to_cycles(GAP_US, CYC_PER_US);
  localparam int          TRY_W    = $clog2(MAX_TRIES + 1);

  seq_state_t        state;
  step_t             step;
  logic [TRY_W-1:0]  tries;
  logic [CNT_W-1:0]  user_cnt;
  logic              cnt_zero;

  // named internal events
  logic              accept, cnt_inc, cnt_dec;
  logic              op_start, op_done;
  logic [CFG_DW-1:0] op_rdata;
  logic              step_pass, poll_fail, last_try, gap_start, gap_done;

  assign busy      = (state != S_IDLE);
  assign accept    = req_valid && (state == S_IDLE);
  assign cnt_inc   = accept && req_enable;
  assign cnt_dec   = accept && !req_enable;
  assign op_start  = (state == S_ISSUE);
  assign step_pass = step_is_write(step) || poll_met(step, op_rdata);
  assign poll_fail = (state == S_WAIT) && op_done && !step_pass;
  assign last_try  = (tries == TRY_W'(MAX_TRIES - 1));
  assign gap_start = poll_fail && !last_try;

  phy_user_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .dec(cnt_dec),
    .count(user_cnt), .is_zero(cnt_zero)
  );

  phy_cfg_port #(.HOLD(HOLD_CYC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .start(op_start),
    .is_write(step_is_write(step)), .addr(step_addr(step)), .wdata(step_wdata(step)),
    .op_done(op_done), .op_rdata(op_rdata),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_wstrobe(cfg_wstrobe),
    .cfg_rdata(cfg_rdata)
  );

  phy_delay #(.CYCLES(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .start(gap_start), .expired(gap_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      step        <= ST_LOCK;
      tries       <= '0;
      phy_rst     <= 1'b1;
      lane_idle   <= '1;
      done        <= 1'b0;
      err_timeout <= 1'b0;
      err_pair    <= 1'b0;
    end else begin
      done        <= 1'b0;
      err_timeout <= 1'b0;
      err_pair    <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (req_enable) begin
            if (cnt_zero) state <= S_RELEASE;
            else          done  <= 1'b1;
          end else if (cnt_zero) begin
            done     <= 1'b1;
            err_pair <= 1'b1;
          end else begin
            lane_idle[req_lane] <= 1'b1;
            done                <= 1'b1;
            if (user_cnt == CNT_W'(1)) phy_rst <= 1'b1;
          end
        end
        S_RELEASE: begin
          phy_rst <= 1'b0;
          state   <= S_UNIDLE;
        end
        S_UNIDLE: begin
          lane_idle <= '0;
          step      <= ST_LOCK;
          tries     <= '0;
          state     <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (op_done) begin
          if (step_pass) begin
            tries <= '0;
            if (step == ST_RELOCK) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              step  <= step_t'(step + 3'd1);
              state <= S_ISSUE;
            end
          end else if (last_try) begin
            done        <= 1'b1;
            err_timeout <= 1'b1;
            state       <= S_IDLE;
          end else begin
            tries <= tries + 1'b1;
            state <= S_GAP;
          end
        end
        S_GAP: if (gap_done) state <= S_ISSUE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_release_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $fell(phy_rst)) |-> (user_cnt == CNT_W'(1)));
  assert_unidle_after_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (|($past(lane_idle) & ~lane_idle))) |-> !phy_rst);
  assert_tries_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tries < TRY_W'(MAX_TRIES));
  assert_err_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_timeout || err_pair) |-> done);
  assert_count_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$stable(user_cnt)) |-> ($past(state) == S_IDLE));
endmodule

// File: tb/tb_phy_pwr_seq.sv
module tb_phy_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CPU   = 2;
  localparam int HUS   = 1;
  localparam int GUS   = 3;
  localparam int TRIES = 5;
  localparam int NEVER = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_enable = 1'b0;
  logic [1:0] req_lane = '0;
  logic       busy, done, err_timeout, err_pair, phy_rst, cfg_wstrobe;
  logic [3:0] lane_idle, cfg_wdata, cfg_rdata;
  logic [5:0] cfg_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_pwr_seq #(.LANES(4), .CNT_W(4), .CYC_PER_US(CPU), .HOLD_US(HUS),
                .GAP_US(GUS), .MAX_TRIES(TRIES)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_enable(req_enable),
    .req_lane(req_lane), .busy(busy), .done(done), .err_timeout(err_timeout),
    .err_pair(err_pair), .phy_rst(phy_rst), .lane_idle(lane_idle),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_wstrobe(cfg_wstrobe),
    .cfg_rdata(cfg_rdata)
  );

  int n_tests = 0, n_fail = 0;

  function automatic int exp_hold();
    return CPU * HUS;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // PHY model: PLL lock / relock and reference gate driven by delays
  int   lock_dly = 3, gate_dly = 3, relock_dly = 3;
  int   lock_cnt = 0, gate_cnt = 0;
  bit   ref_on = 0;
  logic pll_locked, ref_gated;
  assign pll_locked = !phy_rst && (lock_cnt == 0);
  assign ref_gated  = !ref_on || (gate_cnt != 0);
  assign cfg_rdata  = (cfg_addr == 6'h10) ? {2'b00, pll_locked, 1'b0} :
                      (cfg_addr == 6'h12) ? {1'b0, ref_gated, 2'b00} : 4'h0;

  // monitor of strobes and ordering
  int         wr_count = 0;
  logic [5:0] wr_addr [0:63];
  logic [3:0] wr_data [0:63];
  bit         prev_stb = 0, prev_rst = 1;
  logic [5:0] prev_addr = '0;
  int         hi_len = 0, cyc = 0, t_rst_fall = 0, t_unidle = 0;
  logic [3:0] prev_idle = 4'hF;

  always @(negedge clk) begin
    cyc++;
    if (phy_rst) begin
      ref_on   = 0;
      lock_cnt = lock_dly;
      gate_cnt = 0;
    end else begin
      if (lock_cnt > 0) lock_cnt--;
      if (gate_cnt > 0) gate_cnt--;
    end
    if (prev_rst && !phy_rst) t_rst_fall = cyc;
    if (prev_idle != 4'h0 && lane_idle == 4'h0) t_unidle = cyc;
    if (cfg_wstrobe && !prev_stb) begin
      wr_addr[wr_count % 64] = cfg_addr;
      wr_data[wr_count % 64] = cfg_wdata;
      wr_count++;
      chk(cfg_addr == prev_addr, "R6", "address stable at strobe rise", cfg_addr, prev_addr);
      if (cfg_addr == 6'h10 && cfg_wdata[3]) lock_cnt = relock_dly;
      if (cfg_addr == 6'h12 && cfg_wdata[3]) begin ref_on = 1; gate_cnt = gate_dly; end
      hi_len = 1;
    end else if (cfg_wstrobe) hi_len++;
    if (!cfg_wstrobe && prev_stb)
      chk(hi_len == exp_hold(), "R6", "strobe high cycles", hi_len, exp_hold());
    prev_stb  = cfg_wstrobe;
    prev_addr = cfg_addr;
    prev_rst  = phy_rst;
    prev_idle = lane_idle;
  end

  bit r_tmo, r_pair, r_busy;
  int r_writes, r_lat;

  task automatic do_req(input bit en, input int lane, input bit poke);
    int w0;
    @(negedge clk);
    while (busy) @(negedge clk);
    w0 = wr_count;
    req_valid = 1'b1; req_enable = en; req_lane = 2'(lane);
    @(negedge clk);
    req_valid = 1'b0;
    r_busy = busy;
    r_lat = 1;
    while (!done && r_lat < 50000) begin
      if (poke && r_lat < 4) begin req_valid = 1'b1; req_enable = 1'b0; req_lane = 2'd3; end
      else req_valid = 1'b0;
      @(negedge clk);
      r_lat++;
    end
    req_valid = 1'b0;
    r_tmo    = err_timeout;
    r_pair   = err_pair;
    r_writes = wr_count - w0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  int         m_cnt;
  logic [3:0] m_idle;

  initial begin
    int w;
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(phy_rst === 1'b1, "R1", "phy_rst after reset", phy_rst, 1);
    chk(lane_idle === 4'hF, "R1", "lane_idle after reset", lane_idle, 15);
    chk(!busy && !done && !err_timeout && !err_pair && !cfg_wstrobe, "R1",
        "status outputs after reset", {busy, done, err_timeout, err_pair, cfg_wstrobe}, 0);

    // R2 R3 R4 R10: full bring-up, with a disable held against busy
    lock_dly = 5; gate_dly = 3; relock_dly = 4;
    w = wr_count;
    do_req(1, 0, 1);
    chk(r_busy, "R10", "busy during bring-up", r_busy, 1);
    chk(!r_tmo && !r_pair, "R4", "bring-up error flags", {r_tmo, r_pair}, 0);
    chk(r_writes == 2, "R3", "writes in bring-up", r_writes, 2);
    chk(wr_addr[w % 64] == 6'h10 && wr_data[w % 64] == 4'h8, "R3", "first write addr",
        wr_addr[w % 64], 16);
    chk(wr_addr[(w+1) % 64] == 6'h12 && wr_data[(w+1) % 64] == 4'h8, "R3", "second write addr",
        wr_addr[(w+1) % 64], 18);
    chk(t_rst_fall < t_unidle, "R2", "reset released before lanes un-idled", t_rst_fall, t_unidle);
    chk(!phy_rst && lane_idle == 4'h0, "R10", "held request ignored, lanes active",
        lane_idle, 0);

    // R7
    do_req(1, 1, 0);
    chk(r_lat == 1 && r_writes == 0 && !r_tmo && !r_pair, "R7", "repeat enable latency",
        r_lat, 1);
    // R8
    do_req(0, 1, 0);
    chk(lane_idle == 4'b0010 && !phy_rst, "R8", "disable lane1 idles only lane1", lane_idle, 2);
    do_req(0, 0, 0);
    chk(lane_idle == 4'b0011 && phy_rst, "R8", "last disable asserts reset", {phy_rst, lane_idle}, 19);
    // R9
    do_req(0, 3, 0);
    chk(r_pair && !r_tmo, "R9", "pairing error flag", r_pair, 1);
    chk(lane_idle == 4'b0011 && phy_rst, "R9", "misuse changes nothing", {phy_rst, lane_idle}, 19);

    // R5: lock never comes
    lock_dly = NEVER;
    do_req(1, 2, 0);
    chk(r_tmo && r_writes == 0, "R5", "lock timeout", r_tmo, 1);
    chk(!phy_rst, "R5", "reset stays released after timeout", phy_rst, 0);
    lock_dly = 2;
    do_req(1, 3, 0);
    chk(r_lat == 1 && r_writes == 0, "R5", "count kept after timeout", r_lat, 1);
    do_req(0, 3, 0); do_req(0, 2, 0);
    chk(phy_rst, "R8", "reset after two disables", phy_rst, 1);

    // R5: gate never clears
    gate_dly = NEVER;
    do_req(1, 0, 0);
    chk(r_tmo && r_writes == 2, "R5", "ungate timeout", r_tmo, 1);
    do_req(0, 0, 0);
    gate_dly = 3;
    // R5: relock never comes
    relock_dly = NEVER;
    do_req(1, 1, 0);
    chk(r_tmo && r_writes == 2, "R5", "relock timeout", r_tmo, 1);
    do_req(0, 1, 0);
    relock_dly = 3;
    chk(phy_rst, "R8", "reset after timeout run released", phy_rst, 1);

    // random mix against a bench model
    m_cnt = 0;
    m_idle = lane_idle;
    for (int i = 0; i < 40; i++) begin
      bit en;
      int ln;
      en = ($urandom % 2) == 1;
      ln = $urandom % 4;
      lock_dly = $urandom % 12; gate_dly = $urandom % 12; relock_dly = $urandom % 12;
      do_req(en, ln, 0);
      if (en) begin
        if (m_cnt == 0) begin
          m_idle = 4'h0;
          chk(r_writes == 2 && !r_tmo, "R4", "random bring-up", r_writes, 2);
        end else
          chk(r_writes == 0 && r_lat == 1, "R7", "random repeat enable", r_writes, 0);
        m_cnt++;
      end else if (m_cnt == 0) begin
        chk(r_pair, "R9", "random misuse disable", r_pair, 1);
      end else begin
        m_cnt--;
        m_idle[ln] = 1'b1;
        chk(!r_pair, "R8", "random disable no error", r_pair, 0);
      end
      chk(lane_idle == m_idle, "R8", "random lane_idle", lane_idle, m_idle);
      chk(phy_rst == (m_cnt == 0), "R8", "random phy_rst", phy_rst, m_cnt == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule